// File: doc/BRIEF.md
# Background Write Completion Tracker with Fence Stall

This block sits between a processor's store path and the coherence network. A store to a shared location retires in the cycle it is presented. The block takes a free tracking slot for it and sends one invalidation request into the network in the background. The processor carries on without waiting. Each slot records how many invalidation acknowledgements are still owed. The slot is released when the last acknowledgement arrives. The slot index serves as the tag that the network returns with each acknowledgement.

Write completion is enforced only at a fence. A fence is issued at a synchronization point, such as just before a lock is released. The processor holds its fence request, and the block stalls it until every earlier store has collected all of its acknowledgements. This gives weak ordering: stores overlap freely between fences, and all of them are visible once the fence retires.

A small state machine tracks the block's situation. It has three states. `S_EMPTY` means no store is outstanding. `S_PEND` means at least one store is outstanding and no fence is waiting. `S_FENCE` means a fence is held until the outstanding stores drain. The transitions are:
- EMPTY→PEND on a slot allocation.
- PEND→EMPTY when the last busy slot retires with no new allocation.
- PEND→FENCE when a fence is presented while stores are still outstanding.
- FENCE→EMPTY when the last slot retires.

Top module: `bgw_tracker`

## Requirements
- R1: After reset, `cpu_stall`, `inv_valid` and `ack_err` are 0, and no slot is busy.
- R2: A store presented while at least one slot is free is accepted in the same cycle, with `cpu_stall` low.
- R3: The cycle after a store is accepted with a nonzero sharer count, `inv_valid` is 1. In that cycle `inv_addr` equals the store address, `inv_cnt` equals the sharer count, and `inv_tag` is the lowest-numbered slot that was free when the store was accepted. Slots are numbered 0 to SLOTS-1.
- R4: A store with a sharer count of 0 is accepted without a stall. It takes no slot and produces no invalidation request.
- R5: An acknowledgement with `ack_valid`=1 and `ack_tag`=k, arriving while slot k is busy, lowers that slot's count by one. The slot is freed in the cycle after its count goes from 1 to 0.
- R6: A store presented while all slots are busy raises `cpu_stall` in that cycle and is not accepted. This holds even if an acknowledgement frees a slot in the same cycle.
- R7: A fence presented while any slot is busy raises `cpu_stall` combinationally. The stall ends in the first cycle in which no slot is busy.
- R8: A fence presented while no slot is busy completes in that cycle with `cpu_stall` low.
- R9: An acknowledgement whose tag names a free slot raises `ack_err` for one cycle, in the next cycle. It changes no slot.
- R10: A store and an acknowledgement for a different, busy slot in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store request |
| st_addr | input | ADDR_W | Store address |
| st_sharers | input | CNT_W | Number of acknowledgements the store needs |
| fence_valid | input | 1 | Processor fence request, held while stalled |
| cpu_stall | output | 1 | Holds the current processor request |
| inv_valid | output | 1 | Invalidation request to the network |
| inv_addr | output | ADDR_W | Address to invalidate |
| inv_tag | output | TAG_W | Slot tag returned with each acknowledgement |
| inv_cnt | output | CNT_W | Number of copies to invalidate |
| ack_valid | input | 1 | Acknowledgement from the network |
| ack_tag | input | TAG_W | Slot tag of the acknowledgement |
| ack_err | output | 1 | Acknowledgement named a free slot |

## Verification
Random store streams mix zero and nonzero sharer counts. They show whether slot allocation picks the lowest free tag and whether zero-count stores skip the tracker. Random acknowledgement tags land on busy and free slots alike. This separates correct count decrements from spurious ones and exposes missing error pulses. Directed sequences check three things: that a full tracker stalls even when a slot frees in the same cycle; that a fence on an empty tracker passes at once; and that a fence behind pending stores is released exactly one cycle after the final acknowledgement. Cycles carrying both a store and an acknowledgement show whether either event is lost.

// File: rtl/bgw_pkg.sv
package bgw_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_PEND  = 2'd1,
        S_FENCE = 2'd2
    } trk_state_t;
endpackage

// File: rtl/bgw_slot.sv
module bgw_slot #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             ack_hit,
    output logic             busy,
    output logic             retire
);
    logic [CNT_W-1:0] remain;

    // Last outstanding acknowledgement for this slot
    assign retire = ack_hit && busy && (remain == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            remain <= load_cnt;
        end else if (ack_hit && busy) begin
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) busy <= 1'b0;
        end
    end

    AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !busy); // R5
    AST_LOAD_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R3
endmodule

// File: rtl/bgw_pick.sv
module bgw_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     busy,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any_free
);
    always_comb begin
        grant    = '0;
        idx      = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = i[IDX_W-1:0];
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        AST_ONE_GRANT: assert ($onehot0(grant)); // R3
    end
endmodule

// File: rtl/bgw_ctrl.sv
module bgw_ctrl
    import bgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_valid,
    input  logic       fence_valid,
    input  logic       full,
    input  logic       any_busy,
    input  logic       alloc,
    input  logic       last_free,
    output logic       cpu_stall,
    output trk_state_t state
);
    trk_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_EMPTY: if (alloc) nxt = S_PEND;
            S_PEND: begin
                if (last_free && !alloc) nxt = S_EMPTY;
                else if (fence_valid)    nxt = S_FENCE;
            end
            S_FENCE: if (last_free) nxt = S_EMPTY;
            default: nxt = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        cpu_stall = 1'b0;
        unique case (state)
            S_EMPTY: cpu_stall = 1'b0;
            S_PEND:  cpu_stall = fence_valid || (st_valid && full);
            S_FENCE: cpu_stall = 1'b1;
            default: cpu_stall = 1'b0;
        endcase
    end

    AST_STATE_TRACKS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY) == !any_busy); // R7
    AST_EMPTY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY) |-> !cpu_stall); // R8
endmodule

// File: rtl/bgw_tracker.sv
module bgw_tracker #(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 4,
    localparam int TAG_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [CNT_W-1:0]  st_sharers,
    input  logic              fence_valid,
    output logic              cpu_stall,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    output logic [TAG_W-1:0]  inv_tag,
    output logic [CNT_W-1:0]  inv_cnt,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    output logic              ack_err
);
    import bgw_pkg::*;

    logic [SLOTS-1:0] busy_vec;
    logic [SLOTS-1:0] retire_vec;
    logic [SLOTS-1:0] grant;
    logic [TAG_W-1:0] free_idx;
    logic             any_free;
    logic             any_busy;
    logic             full;
    logic             accept;
    logic             alloc;
    logic             single_busy;
    logic             last_free;
    trk_state_t       state;

    assign any_busy    = |busy_vec;
    assign full        = &busy_vec;
    assign accept      = st_valid && !cpu_stall;
    assign alloc       = accept && (st_sharers != '0) && any_free;
    assign single_busy = ((busy_vec & (busy_vec - SLOTS'(1))) == '0);
    assign last_free   = (|retire_vec) && single_busy;

    bgw_pick #(.N(SLOTS), .IDX_W(TAG_W)) u_pick (
        .busy     (busy_vec),
        .grant    (grant),
        .idx      (free_idx),
        .any_free (any_free)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        bgw_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (alloc && grant[g]),
            .load_cnt (st_sharers),
            .ack_hit  (ack_valid && (ack_tag == TAG_W'(g))),
            .busy     (busy_vec[g]),
            .retire   (retire_vec[g])
        );
    end

    bgw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_valid    (st_valid),
        .fence_valid (fence_valid),
        .full        (full),
        .any_busy    (any_busy),
        .alloc       (alloc),
        .last_free   (last_free),
        .cpu_stall   (cpu_stall),
        .state       (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid <= 1'b0;
            inv_addr  <= '0;
            inv_tag   <= '0;
            inv_cnt   <= '0;
            ack_err   <= 1'b0;
        end else begin
            inv_valid <= alloc;
            if (alloc) begin
                inv_addr <= st_addr;
                inv_tag  <= free_idx;
                inv_cnt  <= st_sharers;
            end
            ack_err <= ack_valid && !busy_vec[ack_tag];
        end
    end

    AST_INV_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(st_valid && !cpu_stall)); // R3
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && full) |-> cpu_stall); // R6
    AST_ERR_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> $past(ack_valid)); // R9
    AST_FENCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_valid && any_busy) |-> cpu_stall); // R7
endmodule

// File: tb/bgw_tracker_test.sv
module bgw_tracker_test;
    localparam int SLOTS  = 4;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 4;
    localparam int TAG_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [CNT_W-1:0]  st_sharers = '0;
    logic              fence_valid = 1'b0;
    logic              cpu_stall;
    logic              inv_valid;
    logic [ADDR_W-1:0] inv_addr;
    logic [TAG_W-1:0]  inv_tag;
    logic [CNT_W-1:0]  inv_cnt;
    logic              ack_valid = 1'b0;
    logic [TAG_W-1:0]  ack_tag = '0;
    logic              ack_err;

    int total = 0;
    int bad   = 0;
    bit mbusy [SLOTS];
    int mcnt  [SLOTS];

    always #10 clk = ~clk;

    bgw_tracker #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_sharers(st_sharers), .fence_valid(fence_valid), .cpu_stall(cpu_stall),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_tag(inv_tag), .inv_cnt(inv_cnt),
        .ack_valid(ack_valid), .ack_tag(ack_tag), .ack_err(ack_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int busy_count();
        int n = 0;
        for (int i = 0; i < SLOTS; i++) if (mbusy[i]) n++;
        return n;
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < SLOTS; i++) if (!mbusy[i]) return i;
        return -1;
    endfunction

    // One cycle: drive at negedge, check stall, predict, check registered outputs
    task automatic step(input bit st, input int addr, input int sh,
                        input bit fn, input bit av, input int at, output bit stalled);
        bit exp_stall, acc, exp_inv, exp_err;
        int idx;
        st_valid = st; st_addr = ADDR_W'(addr); st_sharers = CNT_W'(sh);
        fence_valid = fn; ack_valid = av; ack_tag = TAG_W'(at);
        #1;
        exp_stall = (fn && busy_count() > 0) || (st && busy_count() == SLOTS);
        chk(cpu_stall == exp_stall, fn ? "R7/R8 fence stall" : "R2/R6 store stall",
            int'(cpu_stall), int'(exp_stall));
        stalled = cpu_stall;
        acc = st && !exp_stall;
        idx = lowest_free();
        exp_inv = acc && sh != 0;
        exp_err = av && !mbusy[at];
        if (av && mbusy[at]) begin
            mcnt[at]--;
            if (mcnt[at] == 0) mbusy[at] = 0;
        end
        if (exp_inv) begin
            mbusy[idx] = 1;
            mcnt[idx]  = sh;
        end
        @(negedge clk);
        chk(inv_valid == exp_inv, sh == 0 ? "R4 no inv" : "R3 inv_valid",
            int'(inv_valid), int'(exp_inv));
        if (exp_inv && inv_valid) begin
            chk(int'(inv_tag) == idx, "R3 tag", int'(inv_tag), idx);
            chk(int'(inv_addr) == addr, "R3 addr", int'(inv_addr), addr);
            chk(int'(inv_cnt) == sh, "R3 cnt", int'(inv_cnt), sh);
        end
        chk(ack_err == exp_err, "R9 ack_err", int'(ack_err), int'(exp_err));
        st_valid = 0; fence_valid = 0; ack_valid = 0;
    endtask

    task automatic idle();
        bit s;
        step(0, 0, 0, 0, 0, 0, s);
    endtask

    task automatic fence_drain();
        bit s;
        int guard = 0;
        step(0, 0, 0, 1, 0, 0, s);
        while (s && guard < 200) begin
            int t = 0;
            for (int i = SLOTS - 1; i >= 0; i--) if (mbusy[i]) t = i;
            step(0, 0, 0, 1, 1, t, s);
            guard++;
        end
        step(0, 0, 0, 1, 0, 0, s);
        chk(!s && busy_count() == 0, "R7 fence released", int'(s), 0);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        bit s;
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        for (int i = 0; i < SLOTS; i++) begin mbusy[i] = 0; mcnt[i] = 0; end
        repeat (3) @(negedge clk);
        chk(!cpu_stall && !inv_valid && !ack_err, "R1 reset outputs",
            int'({cpu_stall, inv_valid, ack_err}), 0);
        rst_n = 1;
        @(negedge clk);
        // R8: fence on empty tracker
        step(0, 0, 0, 1, 0, 0, s);
        chk(!s, "R8 empty fence", int'(s), 0);
        // R4: zero-sharer store
        step(1, 16'h1234, 0, 0, 0, 0, s);
        chk(busy_count() == 0, "R4 no slot", busy_count(), 0);
        // R9: ack to free slot
        step(0, 0, 0, 0, 1, 2, s);
        // R2/R3: fill all slots
        for (int i = 0; i < SLOTS; i++) step(1, 16'h100 + i, 1 + i % 2, 0, 0, 0, s);
        // R6: full stall with ack freeing slot 0 in same cycle
        step(1, 16'h0abc, 2, 0, 1, 0, s);
        chk(s, "R6 full stall", int'(s), 1);
        // R10: store into freed slot 0 with ack to slot 1 same cycle
        step(1, 16'h0def, 2, 0, 1, 1, s);
        // R5: slot 1 had count 2, one ack left
        step(0, 0, 0, 0, 1, 1, s);
        step(0, 0, 0, 0, 1, 1, s); // now free: R9 error expected
        fence_drain();
        // Random phase
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 4) fence_drain();
            else begin
                bit st = (r < 55);
                bit av = ($urandom_range(0, 2) != 0);
                step(st, $urandom_range(0, 65535), $urandom_range(0, 3), 0,
                     av, $urandom_range(0, SLOTS - 1), s);
            end
        end
        fence_drain();
        idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule